// File: doc/BRIEF.md
# Indirect Message-Bus Register Bridge

This block lets a host reach registers on an internal message bus through three words in a small configuration window. The host loads an optional upper offset into an extension word. For a write it also loads a data word. It then writes a control word, and that write starts the bus transaction. The control word holds the opcode, the target port, the low eight offset bits and the byte-lane enables. The bridge packs these into one message, places the extension bits above the low offset, and presents the message to the bus until the endpoint takes it. It then waits for the endpoint's response.

For a read message, the response data lands in the data word, and the host collects it by reading the data offset. For a write message, the bridge sends the data word's contents. From the control-word write until the response, the bridge is busy. While busy, any host access to the control or data offsets is held off with ready low. Such an access is completed later and is never lost. The extension word stays accessible while busy.

Top module: `msgbus_bridge`

## Requirements
- R1: A control-word write (offset 0xD0) launches one message. Its opcode comes from bits 31:24, its port from bits 23:16 and its byte enables from bits 7:4, and the message is presented on the bus in the cycle after the write is accepted.
- R2: The message offset is {EXT[31:8], CTRL[15:8]}, where EXT is the extension word at offset 0xD8. The extension word reads back with bits 7:0 as zero.
- R3: The opcode is passed through unchanged. 0x06 is the read opcode and 0x07 is the write opcode (parameter defaults), and any other value such as 0x10 also reaches the bus as written.
- R4: A write-opcode message carries the data word (offset 0xD4) as it was loaded before the control write, and sends it on the bus together with the byte enables.
- R5: For a non-write opcode, the response data is stored in the data word only in the cycle the response valid is high. Values on the response data lines while valid is low are never stored. Reading offset 0xD4 afterwards returns the stored response.
- R6: The busy output is high from the cycle after a control write until the cycle after the response. While busy, host accesses to the data offset see ready low.
- R7: A control write that arrives while busy sees ready low until the bridge is idle. It then launches its own message, so no control write is dropped.
- R8: Control-word bits 3:0 are ignored when written and always read back as zero. Bits 31:4 read back as written.
- R9: The bus request stays high with opcode, port, offset, byte enables and write data unchanged until the endpoint asserts ready. Each control write produces exactly one accepted message.
- R10: After reset the bridge is idle, the bus request is low, and all three words read as zero.
- R11: Extension-word accesses are never held off, even while busy. Changing the extension word while busy does not alter the offset of the message in flight.
- R12: A response to a write-opcode (0x07) message leaves the data word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Host access request |
| cfg_we_i | input | 1 | Host access is a write |
| cfg_addr_i | input | AddrW | Host configuration offset |
| cfg_wdata_i | input | 32 | Host write data |
| cfg_rdata_o | output | 32 | Host read data, valid while request and ready are high |
| cfg_rdy_o | output | 1 | Access is accepted on this clock edge |
| busy_o | output | 1 | A bus transaction is in progress |
| mb_valid_o | output | 1 | Message presented to the endpoint |
| mb_ready_i | input | 1 | Endpoint takes the message |
| mb_opcode_o | output | 8 | Message opcode |
| mb_port_o | output | 8 | Message target port |
| mb_offset_o | output | 32 | Message register offset |
| mb_be_o | output | 4 | Message byte enables |
| mb_wdata_o | output | 32 | Message write data |
| mb_rsp_valid_i | input | 1 | Endpoint response strobe |
| mb_rsp_data_i | input | 32 | Endpoint response data |

## Verification
The hardest case to reach is a second control write that arrives while a transaction is still open, because it must be held off and then issued, not dropped. The bench gives the endpoint model programmable delays for taking the message and for responding. It issues back-to-back control writes into a long busy window and counts both the stall cycles and the messages the endpoint takes. The same delayed model drives junk data while response valid is low. It also keeps the request pending while the extension word is rewritten, which exposes the data-latch timing and the point where the in-flight offset is captured.

// File: rtl/msgbus_bridge_pkg.sv
package msgbus_bridge_pkg;
  localparam int unsigned WordW   = 32;
  localparam int unsigned OpW     = 8;
  localparam int unsigned PortW   = 8;
  localparam int unsigned BeW     = 4;
  localparam int unsigned OffLoW  = 8;
  localparam int unsigned ExtW    = WordW - OffLoW;
  // control-word field positions
  localparam int unsigned OpLsb   = 24;
  localparam int unsigned PortLsb = 16;
  localparam int unsigned OffLsb  = 8;
  localparam int unsigned BeLsb   = 4;

  typedef struct packed {
    logic [OpW-1:0]   opcode;
    logic [PortW-1:0] port;
    logic [WordW-1:0] offset;
    logic [BeW-1:0]   be;
    logic [WordW-1:0] wdata;
  } mb_msg_t;

  typedef enum logic [1:0] {SeqIdle, SeqReq, SeqWait} seq_state_e;
endpackage

// File: rtl/bridge_regs.sv
module bridge_regs
  import msgbus_bridge_pkg::*;
#(
  parameter int unsigned     AddrW   = 8,
  parameter logic [AddrW-1:0] CtrlOff = 8'hD0,
  parameter logic [AddrW-1:0] DataOff = 8'hD4,
  parameter logic [AddrW-1:0] ExtOff  = 8'hD8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_req_i,
  input  logic             cfg_we_i,
  input  logic [AddrW-1:0] cfg_addr_i,
  input  logic [WordW-1:0] cfg_wdata_i,
  output logic [WordW-1:0] cfg_rdata_o,
  output logic             cfg_rdy_o,
  input  logic             busy_i,
  input  logic             rsp_load_i,
  input  logic [WordW-1:0] rsp_data_i,
  output logic             launch_o,
  output mb_msg_t          msg_o
);
  localparam int unsigned CtrlW = WordW - BeLsb;

  logic             hit_ctrl, hit_data, hit_ext, acc, wr;
  logic [CtrlW-1:0] ctrl_q;
  logic [ExtW-1:0]  ext_q;
  logic [WordW-1:0] data_q;

  assign hit_ctrl  = cfg_addr_i == CtrlOff;
  assign hit_data  = cfg_addr_i == DataOff;
  assign hit_ext   = cfg_addr_i == ExtOff;
  // control and data words are owned by the sequencer while busy
  assign cfg_rdy_o = !(busy_i && (hit_ctrl || hit_data));
  assign acc       = cfg_req_i && cfg_rdy_o;
  assign wr        = acc && cfg_we_i;
  assign launch_o  = wr && hit_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ext_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr && hit_ctrl) ctrl_q <= cfg_wdata_i[WordW-1:BeLsb];
      if (wr && hit_ext)  ext_q  <= cfg_wdata_i[WordW-1:OffLoW];
      if (wr && hit_data)  data_q <= cfg_wdata_i;
      else if (rsp_load_i) data_q <= rsp_data_i;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (hit_ctrl)      cfg_rdata_o = {ctrl_q, {BeLsb{1'b0}}};
    else if (hit_data) cfg_rdata_o = data_q;
    else if (hit_ext)  cfg_rdata_o = {ext_q, {OffLoW{1'b0}}};
  end

  always_comb begin
    msg_o.opcode = cfg_wdata_i[OpLsb +: OpW];
    msg_o.port   = cfg_wdata_i[PortLsb +: PortW];
    msg_o.offset = {ext_q, cfg_wdata_i[OffLsb +: OffLoW]};
    msg_o.be     = cfg_wdata_i[BeLsb +: BeW];
    msg_o.wdata  = data_q;
  end
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import msgbus_bridge_pkg::*;
#(
  parameter logic [OpW-1:0] WrOpcode = 8'h07
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    launch_i,
  input  mb_msg_t msg_i,
  input  logic    mb_ready_i,
  input  logic    mb_rsp_valid_i,
  output logic    busy_o,
  output logic    mb_valid_o,
  output mb_msg_t msg_o,
  output logic    rsp_load_o
);
  seq_state_e state_q, state_d;
  mb_msg_t    msg_q;
  logic       done;

  assign done = (state_q == SeqWait) && mb_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SeqIdle: if (launch_i)   state_d = SeqReq;
      SeqReq:  if (mb_ready_i) state_d = SeqWait;
      SeqWait: if (done)       state_d = SeqIdle;
      default:                 state_d = SeqIdle;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SeqIdle;
      msg_q   <= '0;
    end else begin
      state_q <= state_d;
      // snapshot at launch keeps the in-flight message immune to host writes
      if (launch_i && state_q == SeqIdle) msg_q <= msg_i;
    end
  end

  assign busy_o     = state_q != SeqIdle;
  assign mb_valid_o = state_q == SeqReq;
  assign msg_o      = msg_q;
  assign rsp_load_o = done && (msg_q.opcode != WrOpcode);
endmodule

// File: rtl/msgbus_bridge.sv
module msgbus_bridge
  import msgbus_bridge_pkg::*;
#(
  parameter int unsigned      AddrW    = 8,
  parameter logic [AddrW-1:0] CtrlOff  = 8'hD0,
  parameter logic [AddrW-1:0] DataOff  = 8'hD4,
  parameter logic [AddrW-1:0] ExtOff   = 8'hD8,
  parameter logic [7:0]       WrOpcode = 8'h07
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_req_i,
  input  logic             cfg_we_i,
  input  logic [AddrW-1:0] cfg_addr_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  output logic             cfg_rdy_o,
  output logic             busy_o,
  output logic             mb_valid_o,
  input  logic             mb_ready_i,
  output logic [7:0]       mb_opcode_o,
  output logic [7:0]       mb_port_o,
  output logic [31:0]      mb_offset_o,
  output logic [3:0]       mb_be_o,
  output logic [31:0]      mb_wdata_o,
  input  logic             mb_rsp_valid_i,
  input  logic [31:0]      mb_rsp_data_i
);
  logic    launch, rsp_load;
  mb_msg_t msg_new, msg_cur;

  bridge_regs #(
    .AddrW(AddrW), .CtrlOff(CtrlOff), .DataOff(DataOff), .ExtOff(ExtOff)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_req_i  (cfg_req_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .cfg_rdy_o  (cfg_rdy_o),
    .busy_i     (busy_o),
    .rsp_load_i (rsp_load),
    .rsp_data_i (mb_rsp_data_i),
    .launch_o   (launch),
    .msg_o      (msg_new)
  );

  bridge_seq #(.WrOpcode(WrOpcode)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .msg_i         (msg_new),
    .mb_ready_i    (mb_ready_i),
    .mb_rsp_valid_i(mb_rsp_valid_i),
    .busy_o        (busy_o),
    .mb_valid_o    (mb_valid_o),
    .msg_o         (msg_cur),
    .rsp_load_o    (rsp_load)
  );

  assign mb_opcode_o = msg_cur.opcode;
  assign mb_port_o   = msg_cur.port;
  assign mb_offset_o = msg_cur.offset;
  assign mb_be_o     = msg_cur.be;
  assign mb_wdata_o  = msg_cur.wdata;
endmodule

// File: rtl/msgbus_bridge_chk.sv
module msgbus_bridge_chk #(
  parameter int unsigned      AddrW   = 8,
  parameter logic [AddrW-1:0] CtrlOff = 8'hD0,
  parameter logic [AddrW-1:0] DataOff = 8'hD4,
  parameter logic [AddrW-1:0] ExtOff  = 8'hD8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_req_i,
  input logic             cfg_we_i,
  input logic [AddrW-1:0] cfg_addr_i,
  input logic [31:0]      cfg_wdata_i,
  input logic [31:0]      cfg_rdata_o,
  input logic             cfg_rdy_o,
  input logic             busy_o,
  input logic             mb_valid_o,
  input logic             mb_ready_i,
  input logic [7:0]       mb_opcode_o,
  input logic [7:0]       mb_port_o,
  input logic [31:0]      mb_offset_o,
  input logic [3:0]       mb_be_o,
  input logic [31:0]      mb_wdata_o,
  input logic             mb_rsp_valid_i
);
  logic ctrl_wr;
  assign ctrl_wr = cfg_req_i && cfg_we_i && cfg_rdy_o && cfg_addr_i == CtrlOff;

  assert_launch_fields_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> mb_valid_o && mb_opcode_o == $past(cfg_wdata_i[31:24])
             && mb_port_o == $past(cfg_wdata_i[23:16]) && mb_be_o == $past(cfg_wdata_i[7:4]));

  assert_req_implies_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_valid_o |-> busy_o);

  assert_data_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cfg_req_i && cfg_addr_i == DataOff |-> !cfg_rdy_o);

  assert_ctrl_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cfg_req_i && cfg_addr_i == CtrlOff |-> !cfg_rdy_o);

  assert_reserved_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i && !cfg_we_i && cfg_rdy_o && cfg_addr_i == CtrlOff |-> cfg_rdata_o[3:0] == 4'h0);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_valid_o && !mb_ready_i |=> mb_valid_o && $stable(mb_opcode_o) && $stable(mb_port_o)
      && $stable(mb_offset_o) && $stable(mb_be_o) && $stable(mb_wdata_o));

  assert_rsp_ends_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mb_valid_o && mb_rsp_valid_i |=> !busy_o);

  assert_ext_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i && cfg_addr_i == ExtOff |-> cfg_rdy_o);
endmodule

bind msgbus_bridge msgbus_bridge_chk #(
  .AddrW(AddrW), .CtrlOff(CtrlOff), .DataOff(DataOff), .ExtOff(ExtOff)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_req_i(cfg_req_i), .cfg_we_i(cfg_we_i),
  .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
  .cfg_rdy_o(cfg_rdy_o), .busy_o(busy_o), .mb_valid_o(mb_valid_o),
  .mb_ready_i(mb_ready_i), .mb_opcode_o(mb_opcode_o), .mb_port_o(mb_port_o),
  .mb_offset_o(mb_offset_o), .mb_be_o(mb_be_o), .mb_wdata_o(mb_wdata_o),
  .mb_rsp_valid_i(mb_rsp_valid_i)
);

// File: tb/sim_msgbus_bridge.sv
`timescale 1ns/1ps
module sim_msgbus_bridge;
  localparam logic [7:0] CTRL = 8'hD0, DATA = 8'hD4, EXT = 8'hD8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_req_i = 1'b0, cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0, cfg_rdata_o;
  logic        cfg_rdy_o, busy_o, mb_valid_o;
  logic        mb_ready_i = 1'b0, mb_rsp_valid_i = 1'b0;
  logic [7:0]  mb_opcode_o, mb_port_o;
  logic [31:0] mb_offset_o, mb_wdata_o;
  logic [3:0]  mb_be_o;
  logic [31:0] mb_rsp_data_i = 32'hDEAD_BEEF;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  msgbus_bridge u0 (.*);

  // endpoint model
  int ready_dly = 0, rsp_dly = 0, rdy_cnt = 0, rsp_cnt = 0, msg_count = 0;
  bit ep_pend = 0, seen = 0, unstable = 0;
  logic [7:0]  ep_op, ep_port, f_op, f_port;
  logic [31:0] ep_off, ep_wd, ep_data, f_off, f_wd;
  logic [3:0]  ep_be, f_be;

  function automatic logic [31:0] rsp_of(logic [31:0] off, logic [7:0] port);
    return off ^ {port, 24'h0} ^ 32'h5A00_00C3;
  endfunction

  always @(negedge clk_i) begin
    mb_ready_i = 1'b0;
    mb_rsp_valid_i = 1'b0;
    mb_rsp_data_i = 32'hDEAD_BEEF;
    if (ep_pend) begin
      if (rsp_cnt >= rsp_dly) begin
        mb_rsp_valid_i = 1'b1;
        mb_rsp_data_i = ep_data;
        ep_pend = 0;
      end else rsp_cnt++;
    end else if (mb_valid_o) begin
      if (!seen) begin
        seen = 1; f_op = mb_opcode_o; f_port = mb_port_o;
        f_off = mb_offset_o; f_be = mb_be_o; f_wd = mb_wdata_o;
      end
      if (rdy_cnt >= ready_dly) begin
        mb_ready_i = 1'b1;
        ep_op = mb_opcode_o; ep_port = mb_port_o; ep_off = mb_offset_o;
        ep_be = mb_be_o; ep_wd = mb_wdata_o;
        if ({f_op, f_port, f_off, f_be, f_wd} != {ep_op, ep_port, ep_off, ep_be, ep_wd})
          unstable = 1;
        ep_data = rsp_of(mb_offset_o, mb_port_o);
        ep_pend = 1; rsp_cnt = 0; rdy_cnt = 0; seen = 0;
        msg_count++;
      end else rdy_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_acc(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd, output int stalls);
    @(negedge clk_i);
    cfg_req_i = 1'b1; cfg_we_i = we; cfg_addr_i = addr; cfg_wdata_i = wd;
    stalls = 0;
    #1;
    while (!cfg_rdy_o) begin
      stalls++;
      @(negedge clk_i); #1;
    end
    rd = cfg_rdata_o;
    @(posedge clk_i); #1;
    cfg_req_i = 1'b0; cfg_we_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] rd; int s;
    cfg_acc(1'b1, addr, wd, rd, s);
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] v);
    int s;
    cfg_acc(1'b0, addr, '0, v, s);
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R10 busy", busy_o, 0);
    chk("R10 mb_valid", mb_valid_o, 0);
    rd(CTRL, v); chk("R10 ctrl", v, 0);
    rd(DATA, v); chk("R10 data", v, 0);
    rd(EXT, v);  chk("R10 ext", v, 0);
  endtask

  task automatic t_read_basic();
    logic [31:0] v; int n0;
    n0 = msg_count;
    wr(CTRL, {8'h06, 8'h12, 8'h34, 4'hF, 4'h0});
    wait_idle();
    chk("R1 opcode", ep_op, 8'h06);
    chk("R1 port", ep_port, 8'h12);
    chk("R1 be", ep_be, 4'hF);
    chk("R2 offset", ep_off, 32'h0000_0034);
    chk("R9 one msg", msg_count - n0, 1);
    rd(DATA, v); chk("R5 read data", v, rsp_of(32'h34, 8'h12));
  endtask

  task automatic t_ext_offset();
    logic [31:0] v;
    wr(EXT, 32'hABCD_EF99);
    rd(EXT, v); chk("R2 ext readback", v, 32'hABCD_EF00);
    wr(CTRL, {8'h06, 8'h21, 8'h5C, 4'hF, 4'h0});
    wait_idle();
    chk("R2 ext offset", ep_off, 32'hABCD_EF5C);
    wr(EXT, 32'h0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    wr(DATA, 32'hCAFE_F00D);
    wr(CTRL, {8'h07, 8'h03, 8'h10, 4'h3, 4'h0});
    wait_idle();
    chk("R3 write opcode", ep_op, 8'h07);
    chk("R4 write data", ep_wd, 32'hCAFE_F00D);
    chk("R4 write be", ep_be, 4'h3);
    rd(DATA, v); chk("R12 data kept", v, 32'hCAFE_F00D);
  endtask

  task automatic t_passthru();
    logic [31:0] v;
    wr(CTRL, {8'h10, 8'h44, 8'h08, 4'h1, 4'h0});
    wait_idle();
    chk("R3 passthru", ep_op, 8'h10);
    rd(DATA, v); chk("R5 other op data", v, rsp_of(32'h08, 8'h44));
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(CTRL, {8'h06, 8'h55, 8'h66, 4'hF, 4'hF});
    rd(CTRL, v);
    chk("R8 reserved", v, {8'h06, 8'h55, 8'h66, 4'hF, 4'h0});
    wait_idle();
  endtask

  task automatic t_busy_stall();
    logic [31:0] v; int s;
    ready_dly = 2; rsp_dly = 4;
    wr(CTRL, {8'h06, 8'h09, 8'h77, 4'hF, 4'h0});
    chk("R6 busy", busy_o, 1);
    cfg_acc(1'b0, DATA, '0, v, s);
    chk("R6 data stalled", (s > 0), 1);
    chk("R5 data after stall", v, rsp_of(32'h77, 8'h09));
    chk("R6 idle after rsp", busy_o, 0);
  endtask

  task automatic t_ctrl_hold();
    logic [31:0] v; int s, n0;
    n0 = msg_count;
    wr(CTRL, {8'h06, 8'h01, 8'h11, 4'hF, 4'h0});
    cfg_acc(1'b1, CTRL, {8'h06, 8'h02, 8'h22, 4'hF, 4'h0}, v, s);
    chk("R7 ctrl stalled", (s > 0), 1);
    wait_idle();
    chk("R7 not dropped", msg_count - n0, 2);
    chk("R7 second port", ep_port, 8'h02);
    chk("R7 second offset", ep_off, 32'h22);
  endtask

  task automatic t_ext_busy();
    logic [31:0] v; int s;
    ready_dly = 4; rsp_dly = 2;
    wr(EXT, 32'h1111_1100);
    wr(CTRL, {8'h06, 8'h05, 8'h33, 4'hF, 4'h0});
    cfg_acc(1'b1, EXT, 32'h2222_2200, v, s);
    chk("R11 ext no stall", s, 0);
    chk("R11 still busy", busy_o, 1);
    wait_idle();
    chk("R11 inflight offset", ep_off, 32'h1111_1133);
    chk("R9 fields stable", unstable, 0);
    rd(EXT, v); chk("R11 ext written", v, 32'h2222_2200);
    wr(EXT, 32'h0);
    ready_dly = 0; rsp_dly = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_read_basic();
    t_ext_offset();
    t_write();
    t_passthru();
    t_reserved();
    t_busy_stall();
    t_ctrl_hold();
    t_ext_busy();
    repeat (4) @(posedge clk_i);
    finish_run();
  end
endmodule